// File: doc/BRIEF.md
# Latched Masked Interrupt Controller

This block gathers three internal event sources (counter overflow, timer overflow and a periodic time-base tick) and turns them into one request towards the CPU sequencer. Each source pulse is caught in its own pending latch. A latch only reaches the CPU when its mask bit is set and the global enable flip-flop is on. When more than one source is armed, the block picks the highest-priority one and presents that source's fixed entry address on the vector output.

The sequencer answers a request with an accept strobe. On that edge the block drops the global enable and clears the latch of the source it took. A later return strobe turns the global enable back on. Software can load the mask, clear latches selectively, and set or clear the global enable. It has no path that sets a latch. Saving the program counter and the flags is the sequencer's job. Only the strobes cross this boundary.

Top module: `intc_top`

## Requirements
- R1: The vector output carries 0x006 when the counter source (request bit 2) wins, 0x008 when the timer source (bit 1) wins, and 0x00A when the time-base source (bit 0) wins. The vector output is 0 while the request output is low.
- R2: The request output is high exactly when the global enable is 1 and at least one source has both its latch and its mask bit set. A pending latch is held while it is masked or while the global enable is off.
- R3: A mask write loads all three mask bits at once, with bit 2 belonging to the counter, bit 1 to the timer and bit 0 to the time base.
- R4: Only a request pulse sets a latch. A latch-clear write clears every latch whose data bit is 1 and leaves the latches whose data bit is 0 untouched. No software write sets a latch.
- R5: An accept while the request is high clears the global enable and clears the latch of the winning source only. An accept while the request is low has no effect.
- R6: A return strobe sets the global enable to 1.
- R7: When several armed sources compete, the counter beats the timer and the timer beats the time base.
- R8: Reset clears all latches, all mask bits and the global enable.
- R9: A request pulse in the same cycle as a clear of that latch, whether from a software clear or from an accept, leaves the latch set.
- R10: The enable-set strobe turns the global enable on and the enable-clear strobe turns it off. When a clear (enable-clear or accept) and a set (enable-set or return) arrive in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqPulse | input | NUM_SRC | Source pulses: bit 2 counter, bit 1 timer, bit 0 time base |
| maskWrEn | input | 1 | Load the mask register from maskWrData |
| maskWrData | input | NUM_SRC | New mask value |
| latchClrEn | input | 1 | Clear the latches selected by latchClrData |
| latchClrData | input | NUM_SRC | A 1 clears that latch |
| enSet | input | 1 | Set the global enable |
| enClr | input | 1 | Clear the global enable |
| accept | input | 1 | Sequencer takes the presented interrupt |
| retStrobe | input | 1 | Return from interrupt |
| irqOut | output | 1 | Interrupt request to the sequencer |
| irqVector | output | VEC_W | Entry address of the winning source |

## Verification
The bench builds the block with its default parameters: three sources, a 12-bit vector, base 0x006 and step 2. With these values every mask pattern and every combination of pending latches can be reached in a few cycles. A bench-side model, written from the requirements, predicts the request and the vector after every edge. The runs cover pending latches held while the enable is off, mask bits steering priority, clears that collide with fresh pulses, set and clear strobes in the same cycle, and a reset in the middle of a run.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Strobes the control half issues to the datapath half each cycle.
  typedef struct packed {
    logic ackTake;   // accepted: clear the winning latch
    logic maskLoad;  // load the mask register
    logic swClear;   // software latch clear
  } ctrlStrobe_t;

  typedef enum logic {
    GIE_OFF = 1'b0,
    GIE_ON  = 1'b1
  } gieState_t;

endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 3,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 6,
  parameter int VEC_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic [NUM_SRC-1:0] latchClrData,
  input  ctrlStrobe_t        strobe,
  output logic               armedAny,
  output logic [NUM_SRC-1:0] latchQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [VEC_W-1:0]   winVec
);

  localparam int TOP_IDX = NUM_SRC - 1;

  logic [NUM_SRC-1:0] armed;
  logic [NUM_SRC-1:0] winOneHot;

  assign armed    = latchQ & maskQ;
  assign armedAny = |armed;

  // Fixed priority: the highest index wins.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    if (g == TOP_IDX) begin : g_top
      assign winOneHot[g] = armed[g];
    end else begin : g_low
      assign winOneHot[g] = armed[g] & ~(|armed[TOP_IDX:g+1]);
    end
  end

  // Entry address: the highest-priority source takes the base, then each step down.
  always_comb begin
    winVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (winOneHot[i]) begin
        winVec = winVec | VEC_W'(VEC_BASE + VEC_STEP * (TOP_IDX - i));
      end
    end
  end

  // Pending latches: a fresh pulse wins over any clear.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_latch
    logic dropBit;
    assign dropBit = (strobe.swClear & latchClrData[g]) | (strobe.ackTake & winOneHot[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchQ[g] <= 1'b0;
      end else begin
        latchQ[g] <= reqPulse[g] | (latchQ[g] & ~dropBit);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.maskLoad) begin
      maskQ <= maskWrData;
    end
  end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armedAny,
  input  logic        maskWrEn,
  input  logic        latchClrEn,
  input  logic        enSet,
  input  logic        enClr,
  input  logic        accept,
  input  logic        retStrobe,
  output ctrlStrobe_t strobe,
  output logic        gieOn,
  output logic        irqOut
);

  gieState_t gieQ;
  gieState_t gieNext;
  logic      takeNow;

  assign gieOn   = (gieQ == GIE_ON);
  assign irqOut  = gieOn & armedAny;
  assign takeNow = accept & irqOut;

  always_comb begin
    gieNext = gieQ;
    if (takeNow || enClr) begin
      gieNext = GIE_OFF;
    end else if (retStrobe || enSet) begin
      gieNext = GIE_ON;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ <= GIE_OFF;
    end else begin
      gieQ <= gieNext;
    end
  end

  always_comb begin
    strobe.ackTake  = takeNow;
    strobe.maskLoad = maskWrEn;
    strobe.swClear  = latchClrEn;
  end

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 3,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 6,
  parameter int VEC_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               latchClrEn,
  input  logic [NUM_SRC-1:0] latchClrData,
  input  logic               enSet,
  input  logic               enClr,
  input  logic               accept,
  input  logic               retStrobe,
  output logic               irqOut,
  output logic [VEC_W-1:0]   irqVector
);

  ctrlStrobe_t        strobe;
  logic               armedAny;
  logic               gieOn;
  logic [NUM_SRC-1:0] latchQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [VEC_W-1:0]   winVec;

  intc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .armedAny   (armedAny),
    .maskWrEn   (maskWrEn),
    .latchClrEn (latchClrEn),
    .enSet      (enSet),
    .enClr      (enClr),
    .accept     (accept),
    .retStrobe  (retStrobe),
    .strobe     (strobe),
    .gieOn      (gieOn),
    .irqOut     (irqOut)
  );

  intc_datapath #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqPulse     (reqPulse),
    .maskWrData   (maskWrData),
    .latchClrData (latchClrData),
    .strobe       (strobe),
    .armedAny     (armedAny),
    .latchQ       (latchQ),
    .maskQ        (maskQ),
    .winVec       (winVec)
  );

  assign irqVector = irqOut ? winVec : '0;

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC  = 3,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 6,
  parameter int VEC_STEP = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqPulse,
  input logic               enClr,
  input logic               accept,
  input logic               retStrobe,
  input logic               irqOut,
  input logic [VEC_W-1:0]   irqVector,
  input logic [NUM_SRC-1:0] latchQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               gieOn
);

  localparam int VEC_LAST = VEC_BASE + VEC_STEP * (NUM_SRC - 1);

  assert_vec_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (int'(irqVector) >= VEC_BASE && int'(irqVector) <= VEC_LAST));

  assert_vec_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqVector == '0));

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (gieOn && ((latchQ & maskQ) != '0)));

  assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(reqPulse)) == '0));

  assert_accept_gie_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && irqOut) |=> !gieOn);

  assert_accept_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && irqOut && reqPulse == '0) |=> ($countones(latchQ) + 1 == $countones($past(latchQ))));

  assert_return_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !enClr && !(accept && irqOut)) |=> gieOn);

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqPulse != '0) |=> ((latchQ & $past(reqPulse)) == $past(reqPulse)));

  // R8: while reset is held, all state sits at zero
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_R8: assert (latchQ == '0 && maskQ == '0 && !gieOn);
    end
  end

endmodule

bind intc_top intc_checker #(
  .NUM_SRC  (NUM_SRC),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqPulse  (reqPulse),
  .enClr     (enClr),
  .accept    (accept),
  .retStrobe (retStrobe),
  .irqOut    (irqOut),
  .irqVector (irqVector),
  .latchQ    (latchQ),
  .maskQ     (maskQ),
  .gieOn     (gieOn)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  reqPulse = '0;
  logic        maskWrEn = 1'b0;
  logic [2:0]  maskWrData = '0;
  logic        latchClrEn = 1'b0;
  logic [2:0]  latchClrData = '0;
  logic        enSet = 1'b0;
  logic        enClr = 1'b0;
  logic        accept = 1'b0;
  logic        retStrobe = 1'b0;
  logic        irqOut;
  logic [11:0] irqVector;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic        irq;
    logic [11:0] vec;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // Bench model state, built from the requirements
  logic [2:0] mLat = '0;
  logic [2:0] mMsk = '0;
  logic       mGie = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .latchClrEn(latchClrEn), .latchClrData(latchClrData),
    .enSet(enSet), .enClr(enClr), .accept(accept), .retStrobe(retStrobe),
    .irqOut(irqOut), .irqVector(irqVector)
  );

  // R1 entry addresses, R7 priority counter > timer > time base
  function automatic logic [11:0] entryOf(input logic [2:0] armed);
    if (armed[2]) return 12'h006;
    if (armed[1]) return 12'h008;
    if (armed[0]) return 12'h00A;
    return 12'h000;
  endfunction

  function automatic logic [2:0] winnerOf(input logic [2:0] armed);
    if (armed[2]) return 3'b100;
    if (armed[1]) return 3'b010;
    if (armed[0]) return 3'b001;
    return 3'b000;
  endfunction

  task automatic check(input logic aIrq, input logic [11:0] aVec,
                       input logic eIrq, input logic [11:0] eVec, input string tag);
    applied++;
    if (aIrq !== eIrq || aVec !== eVec) begin
      bad++;
      $display("FAIL %s: actual irq=%0b vec=0x%03h expected irq=%0b vec=0x%03h",
               tag, aIrq, aVec, eIrq, eVec);
    end
  endtask

  // Monitor: pops expected items and compares after each edge
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(irqOut, irqVector, it.irq, it.vec, it.tag);
    end
  end

  // Driver: applies one cycle of stimulus and pushes the predicted result
  task automatic drive(input logic [2:0] rq, input logic mwe, input logic [2:0] md,
                       input logic cwe, input logic [2:0] cd, input logic es,
                       input logic ec, input logic ac, input logic rt, input string tag);
    logic       irqNow;
    logic       take;
    logic [2:0] win;
    expItem_t   it;
    reqPulse = rq; maskWrEn = mwe; maskWrData = md;
    latchClrEn = cwe; latchClrData = cd;
    enSet = es; enClr = ec; accept = ac; retStrobe = rt;
    irqNow = mGie && ((mLat & mMsk) != 3'b000);
    win    = winnerOf(mLat & mMsk);
    take   = ac && irqNow;
    @(posedge clk);
    mLat = (mLat & ~(cwe ? cd : 3'b000) & ~(take ? win : 3'b000)) | rq;
    if (mwe) mMsk = md;
    if (take || ec) mGie = 1'b0;
    else if (rt || es) mGie = 1'b1;
    it.irq = mGie && ((mLat & mMsk) != 3'b000);
    it.vec = it.irq ? entryOf(mLat & mMsk) : 12'h000;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    reqPulse = '0; maskWrEn = 0; maskWrData = '0; latchClrEn = 0; latchClrData = '0;
    enSet = 0; enClr = 0; accept = 0; retStrobe = 0;
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    rstN = 1'b0;
    mLat = '0; mMsk = '0; mGie = 1'b0;
    @(posedge clk);
    #2;
    check(irqOut, irqVector, 1'b0, 12'h000, tag);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(irqOut, irqVector, 1'b0, 12'h000, "R8 reset state");
    @(negedge clk);
    rstN = 1'b1;

    //   rq    mwe md     cwe cd     es ec ac rt
    drive(3'b111, 0, 3'b000, 0, 3'b000, 0, 0, 0, 0, "R2 latched but masked and disabled");
    drive(3'b000, 1, 3'b001, 0, 3'b000, 0, 0, 0, 0, "R2 masked in but enable off");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 1, 0, 0, 0, "R1 R3 time base vector");
    drive(3'b000, 1, 3'b111, 0, 3'b000, 0, 0, 0, 0, "R7 counter wins");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 1, 0, "R5 accept drops enable");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 1, 0, "R5 accept ignored when idle");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 0, 1, "R6 return, timer next");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 1, 0, "R5 take timer");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 0, 1, "R6 R7 time base last");
    drive(3'b000, 0, 3'b000, 1, 3'b000, 0, 0, 0, 0, "R4 zero clear bits no effect");
    drive(3'b000, 0, 3'b000, 1, 3'b001, 0, 0, 0, 0, "R4 software clear");
    drive(3'b000, 0, 3'b000, 1, 3'b111, 0, 0, 0, 0, "R4 clear cannot set");
    drive(3'b010, 0, 3'b000, 1, 3'b010, 0, 0, 0, 0, "R9 pulse beats software clear");
    drive(3'b100, 0, 3'b000, 0, 3'b000, 0, 0, 0, 0, "R7 counter over timer");
    drive(3'b100, 0, 3'b000, 0, 3'b000, 0, 0, 1, 0, "R9 pulse beats accept clear");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 1, 1, 0, 0, "R10 clear wins over set");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 1, 0, 0, 0, "R10 set");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 1, 0, 1, 0, "R10 accept wins over set");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 0, 1, "R6 return again");
    drive(3'b000, 1, 3'b010, 0, 3'b000, 0, 0, 0, 0, "R3 mask selects timer");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 1, 0, 0, "R10 enable clear");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 0, 1, "R2 pending held while off");
    drive(3'b001, 1, 3'b001, 0, 3'b000, 0, 0, 0, 0, "R3 mask time base only");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 0, 0, 1, 1, "R5 R10 accept with return");

    doReset("R8 reset mid-run");
    drive(3'b000, 0, 3'b000, 0, 3'b000, 1, 0, 0, 0, "R8 latches and mask cleared");
    drive(3'b000, 1, 3'b111, 0, 3'b000, 0, 0, 0, 0, "R8 no stale latch");
    drive(3'b010, 0, 3'b000, 0, 3'b000, 0, 0, 0, 0, "R1 timer vector");

    @(posedge clk);
    #4;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule